// File: doc/BRIEF.md
# Two-Byte UART-Framed Word Transmitter

This block sends a 16-bit result over a single serial wire as two characters that any UART receiver can frame. A strobe loads the word into a held output register. The serial clock comes from outside the chip and sets the bit rate. An active-low select asks for one character at a time. The upper half of the word goes out first and the lower half second. Each character has a low start bit, the eight data bits with the lowest index first, and two high stop bits. Between characters the output enable is dropped, so the line can be shared.

A byte pointer tracks which half of the word goes next. A ready flag, active low, stays asserted from the moment a word is loaded until its second character has left. If a new word arrives while a character is on the line, it is discarded. If it arrives in the gap between the two characters, it replaces the held word, and the next character is the upper half of the new word. Serial clock and select are brought into the system clock domain before any edge is seen.

Top module: `uart_word_sender`

## Requirements
- R1: After reset, sdataOe is 0 and drdyN is 1.
- R2: When csN is low at a falling serial-clock edge, drdyN is low and no character is in progress, a character begins. At that edge sdataOe goes to 1 and sdata carries the start bit, which is 0.
- R3: A character spans 11 bit periods, each one serial-clock period long: one start bit (0), eight data bits, then two stop bits (1).
- R4: The first character after a load carries word bits 15 to 8. The second carries bits 7 to 0.
- R5: Within a character the data bits go out lowest index first, so the bit right after the start bit is word bit 8 or word bit 0.
- R6: At the falling edge after the last stop bit, sdataOe returns to 0. Another character begins only after csN has been seen high and then low again.
- R7: A new word offered while a character is in progress is discarded, and the character and its successor come from the old word.
- R8: A new word offered between characters replaces the held word, and the next character is its upper half.
- R9: Loading a word drives drdyN to 0 and points the byte pointer at the upper half.
- R10: At the end of the second character drdyN goes to 1. It stays at 1 until the next load, and no character begins while drdyN is 1.
- R11: sdata and sdataOe change only in the cycle that follows a detected falling edge of the synchronized serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclkIn | input | 1 | External serial bit clock, asynchronous |
| csN | input | 1 | Character request, active low, asynchronous |
| newWordValid | input | 1 | One-cycle strobe that offers a new word |
| newWord | input | 16 | Word offered with the strobe |
| sdata | output | 1 | Serial data, valid while sdataOe is 1 |
| sdataOe | output | 1 | Output enable for the three-state serial pin |
| drdyN | output | 1 | Word ready, active low |

## Verification
The assertions assume that the serial clock is much slower than the system clock. Each level then lasts long enough to pass through the synchronizer, and every falling edge appears as exactly one detected edge. They also assume that newWordValid is a single-cycle strobe. The stimulus holds each serial-clock level for eight system cycles. It changes csN and the strobe only while the serial clock is high and far from any edge. It samples the line six cycles after each falling edge, which is past the three-register path from pin to output.

// File: rtl/uws_pkg.sv
package uws_pkg;
  typedef struct packed {
    logic load;      // capture the offered word
    logic startByte; // begin a character
    logic shiftBit;  // advance to the next bit
    logic endByte;   // release the line
    logic selLower;  // pointer: 0 upper half, 1 lower half
  } uwsStrobes_t;
endpackage

// File: rtl/uws_sync.sv
module uws_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= RST_VAL;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RST_VAL}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uws_ctrl.sv
module uws_ctrl
  import uws_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STOP_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        csN,
  input  logic        newWordValid,
  output uwsStrobes_t strobes,
  output logic        fallEdge,
  output logic        drdyN
);
  localparam int HALF  = DATA_W / 2;
  localparam int FRAME = 1 + HALF + STOP_BITS;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME - 1);

  logic sclkSync, csSync, sclkPrev;
  logic busy, armed, lowerSel;
  logic [CNT_W-1:0] bitCnt;
  logic load, startByte, shiftBit, endByte;

  uws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclkSync (
    .clk(clk), .rstN(rstN), .din(sclkIn), .dout(sclkSync));
  uws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkSync;
  end

  assign fallEdge = sclkPrev & ~sclkSync;

  always_comb begin
    load      = newWordValid && !busy;
    startByte = fallEdge && !busy && !csSync && armed && !drdyN && !newWordValid;
    shiftBit  = fallEdge && busy && (bitCnt != LAST_BIT);
    endByte   = fallEdge && busy && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      armed    <= 1'b0;
      lowerSel <= 1'b0;
      bitCnt   <= '0;
      drdyN    <= 1'b1;
    end else begin
      if (csSync && !busy) armed <= 1'b1;
      if (load) begin
        lowerSel <= 1'b0;
        drdyN    <= 1'b0;
      end
      if (startByte) begin
        busy   <= 1'b1;
        armed  <= 1'b0;
        bitCnt <= '0;
      end
      if (shiftBit) bitCnt <= bitCnt + 1'b1;
      if (endByte) begin
        busy     <= 1'b0;
        lowerSel <= ~lowerSel;
        if (lowerSel) drdyN <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load      = load;
    strobes.startByte = startByte;
    strobes.shiftBit  = shiftBit;
    strobes.endByte   = endByte;
    strobes.selLower  = lowerSel;
  end
endmodule

// File: rtl/uws_datapath.sv
module uws_datapath
  import uws_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  uwsStrobes_t       strobes,
  input  logic [DATA_W-1:0] newWord,
  output logic [DATA_W-1:0] heldWord,
  output logic              sdata,
  output logic              sdataOe
);
  localparam int HALF  = DATA_W / 2;
  localparam int FRAME = 1 + HALF + STOP_BITS;

  logic [FRAME-1:0] frameReg;
  logic [HALF-1:0]  byteSel;

  assign byteSel = strobes.selLower ? heldWord[HALF-1:0] : heldWord[DATA_W-1:HALF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldWord <= '0;
    else if (strobes.load) heldWord <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
      sdataOe  <= 1'b0;
    end else begin
      if (strobes.startByte) begin
        frameReg <= {{STOP_BITS{1'b1}}, byteSel, 1'b0};
        sdataOe  <= 1'b1;
      end else if (strobes.shiftBit) begin
        frameReg <= {1'b1, frameReg[FRAME-1:1]};
      end else if (strobes.endByte) begin
        frameReg <= '1;
        sdataOe  <= 1'b0;
      end
    end
  end

  assign sdata = frameReg[0];
endmodule

// File: rtl/uart_word_sender.sv
module uart_word_sender
  import uws_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STOP_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csN,
  input  logic              newWordValid,
  input  logic [DATA_W-1:0] newWord,
  output logic              sdata,
  output logic              sdataOe,
  output logic              drdyN
);
  uwsStrobes_t       strobes;
  logic              fallEdge;
  logic [DATA_W-1:0] heldWord;

  uws_ctrl #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN),
    .newWordValid(newWordValid), .strobes(strobes), .fallEdge(fallEdge), .drdyN(drdyN));

  uws_datapath #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .newWord(newWord),
    .heldWord(heldWord), .sdata(sdata), .sdataOe(sdataOe));
endmodule

// File: rtl/uws_checker.sv
module uws_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdata,
  input logic              sdataOe,
  input logic              drdyN,
  input logic              fallEdge,
  input logic              selLower,
  input logic [DATA_W-1:0] heldWord
);
  assert_line_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !fallEdge |=> ($stable(sdata) && $stable(sdataOe)));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> !sdata);

  assert_word_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdataOe |=> $stable(heldWord));

  assert_ready_at_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drdyN) |-> $fell(sdataOe));

  assert_no_start_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> !drdyN);

  assert_load_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> !selLower);
endmodule

bind uart_word_sender uws_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdata(sdata), .sdataOe(sdataOe), .drdyN(drdyN),
  .fallEdge(fallEdge), .selLower(strobes.selLower), .heldWord(heldWord));

// File: tb/uart_word_sender_bench.sv
module uart_word_sender_bench;
  typedef struct {
    logic  oe;
    logic  bitVal;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN, sclkIn, csN, newWordValid;
  logic [15:0] newWord;
  logic        sdata, sdataOe, drdyN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t expQ[$];
  event sampleEv;

  always #2.5 clk = ~clk;

  uart_word_sender u_uart_word_sender (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN),
    .newWordValid(newWordValid), .newWord(newWord),
    .sdata(sdata), .sdataOe(sdataOe), .drdyN(drdyN));

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops each expected line state and compares against the pins
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkVal({it.tag, " oe"}, {15'd0, sdataOe}, {15'd0, it.oe});
        if (it.oe) checkVal({it.tag, " bit"}, {15'd0, sdata}, {15'd0, it.bitVal});
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadWord(input logic [15:0] w);
    newWord = w; newWordValid = 1'b1;
    waitClk(1);
    newWordValid = 1'b0;
  endtask

  // one serial-clock fall, then sample the line six cycles later
  task automatic fallAndExpect(input logic oe, input logic b, input string tag);
    sclkIn = 1'b0;
    waitClk(6);
    expQ.push_back('{oe: oe, bitVal: b, tag: tag});
    -> sampleEv;
    waitClk(2);
    sclkIn = 1'b1;
    waitClk(8);
  endtask

  task automatic sendByte(input logic [7:0] b, input string dataTag,
                          input logic inject, input logic [15:0] injWord);
    csN = 1'b0;
    waitClk(4);
    fallAndExpect(1'b1, 1'b0, "R2 start");
    for (int k = 0; k < 8; k++) begin
      fallAndExpect(1'b1, b[k], dataTag);
      if (inject && k == 3) loadWord(injWord);
    end
    fallAndExpect(1'b1, 1'b1, "R3 stop1");
    fallAndExpect(1'b1, 1'b1, "R3 stop2");
    fallAndExpect(1'b0, 1'b0, "R6 release");
    fallAndExpect(1'b0, 1'b0, "R6 no restart");
    csN = 1'b1;
    waitClk(8);
  endtask

  initial begin
    rstN = 1'b0; sclkIn = 1'b1; csN = 1'b1; newWordValid = 1'b0; newWord = '0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(6);
    checkVal("R1 oe", {15'd0, sdataOe}, 16'd0);
    checkVal("R1 drdy", {15'd0, drdyN}, 16'd1);

    // no word pending: request must not start a character
    csN = 1'b0; waitClk(4);
    fallAndExpect(1'b0, 1'b0, "R10 idle");
    fallAndExpect(1'b0, 1'b0, "R10 idle");
    csN = 1'b1; waitClk(8);

    loadWord(16'hA5C3); waitClk(2);
    checkVal("R9 drdy", {15'd0, drdyN}, 16'd0);
    sendByte(8'hA5, "R4 R5 upper", 1'b0, 16'h0);
    checkVal("R10 mid", {15'd0, drdyN}, 16'd0);
    sendByte(8'hC3, "R4 R5 lower", 1'b0, 16'h0);
    checkVal("R10 drdy", {15'd0, drdyN}, 16'd1);

    // word offered mid-character is discarded
    loadWord(16'h1234); waitClk(2);
    sendByte(8'h12, "R4 upper", 1'b0, 16'h0);
    sendByte(8'h34, "R7 lower", 1'b1, 16'hFFFF);
    checkVal("R7 drdy", {15'd0, drdyN}, 16'd1);

    // word offered between characters replaces held word
    loadWord(16'h3C96); waitClk(2);
    sendByte(8'h3C, "R4 upper", 1'b0, 16'h0);
    loadWord(16'h5AE1); waitClk(2);
    checkVal("R8 drdy", {15'd0, drdyN}, 16'd0);
    sendByte(8'h5A, "R8 new upper", 1'b0, 16'h0);
    sendByte(8'hE1, "R8 new lower", 1'b0, 16'h0);
    checkVal("R10 final", {15'd0, drdyN}, 16'd1);

    waitClk(4);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule